// File: doc/BRIEF.md
# Security Code Gate

This block decides whether the memory behind it may be written or erased. It holds an attempt counter byte and a two-byte secret code, and it follows decoded commands from the serial front end. To open the gate, the host first clears one bit of the counter that is still set. This spends an attempt. The host then presents the low code byte and the high code byte, in that order, with verify commands. When both bytes match, the gate opens and the write grant goes high. While the gate is open, the counter may be loaded with any value, so spent attempts can be given back, and the code bytes may be replaced unless their lock bits have been cleared.

Reads of memory also pass through the block. A read of the counter address returns the live counter. A read of either code address returns zero. A read of any other address passes the memory data through unchanged. When every counter bit is zero, no further attempt can be started. The gate can then never open again. Reset models power-up: the gate closes and the stored bytes return to their factory values, which are parameters.

The counter sits at the third-last address of the space, the low code byte at the second-last and the high code byte at the last (1021, 1022 and 1023 for a 10-bit address).

Top module: `sc_gate`

## Requirements
- R1: After reset, `wr_grant` is 0, the counter reads FFh (its factory value) and the code bytes hold their factory values.
- R2: While the gate is closed, a counter write (opcode 1, counter address) stores the AND of the old counter and the written data, so bits can only be cleared.
- R3: A counter write while closed starts an attempt only if it clears at least one bit that was set; a write that clears nothing starts no attempt.
- R4: After an attempt starts, a verify (opcode 2) of the low code address that matches, followed by a matching verify of the high code address, opens the gate; `wr_grant` rises on the second clock edge after the last verify.
- R5: A verify with no attempt started, or a verify of the high byte before the low byte has matched, fails and leaves the gate closed.
- R6: Any mismatching verify closes the gate and ends the attempt, including when the gate is already open; `wr_grant` falls accordingly.
- R7: While the gate is open, a counter write loads the written data directly, so the counter can be restored to FFh; the gate stays open.
- R8: With the counter at 00h, no attempt can start and verifies never open the gate; an attempt started by clearing the last set bit is still usable.
- R9: A read (`rd_en`) returns on `rd_data` one edge later: 00h for either code address, the counter for the counter address, and `rd_mem_data` for any other address.
- R10: A code write (opcode 3, or opcode 4 which also clears that byte's lock bit) replaces a code byte only while the gate is open and that byte's lock bit is still 1; otherwise it is ignored.
- R11: A counter write aimed at any address other than the counter address is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | 0 none, 1 counter write, 2 verify, 3 code write, 4 code write and lock |
| cmd_addr | input | ADDR_W | Target address of the command |
| cmd_data | input | DATA_W | Command data: counter mask, compare byte or new code byte |
| rd_en | input | 1 | A memory read is being returned |
| rd_addr | input | ADDR_W | Address of the read |
| rd_mem_data | input | DATA_W | Data from the memory array for that read |
| rd_data | output | DATA_W | Masked read data, registered |
| wr_grant | output | 1 | Write and erase permission for the memory, registered |

## Verification
The unlock sequence is tried in its proper form, with verifies but no spent attempt, with a bit-clearing write that clears nothing, with the two code bytes in reverse order, and with a wrong byte in either position. Each failing pattern shows that one stage of the ordering is enforced on its own. Further patterns cover a mismatch after the gate has opened, a counter write to a neighbouring address, and the counter at zero. The last of these is checked both before and after the final bit is spent, which separates "no attempts left" from "last attempt in progress". Code rewriting is checked against lock bits and against the closed state by verifying the byte afterwards, because a stored code can only be observed through a match.

// File: rtl/sc_gate_pkg.sv
`timescale 1ns/1ps
package sc_gate_pkg;
  typedef enum logic [2:0] {
    OP_NONE         = 3'd0,
    OP_CNT_WR       = 3'd1,
    OP_VERIFY       = 3'd2,
    OP_CODE_WR      = 3'd3,
    OP_CODE_WR_LOCK = 3'd4
  } sc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HALF  = 2'd2,
    ST_OPEN  = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_attempt_ctr.sv
`timescale 1ns/1ps
module sc_attempt_ctr #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              unlocked,
  output logic [DATA_W-1:0] cnt,
  output logic              spend
);
  // an attempt is spent only when a set bit is actually cleared
  always_comb spend = wr_en && !unlocked && ((cnt & ~wr_data) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= INIT;
    end else if (wr_en) begin
      cnt <= unlocked ? wr_data : (cnt & wr_data);
    end
  end
endmodule

// File: rtl/sc_code_store.sv
`timescale 1ns/1ps
module sc_code_store #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_LO = '0,
  parameter logic [DATA_W-1:0] INIT_HI = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             wr_en,
  input  logic                   wr_lock,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   unlocked,
  output logic [1:0][DATA_W-1:0] code
);
  localparam int unsigned NBYTES = 2;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [DATA_W-1:0] BYTE_INIT = (g == 0) ? INIT_LO : INIT_HI;
    logic [DATA_W-1:0] byte_q;
    logic              open_q;  // 1: byte may still be rewritten

    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= BYTE_INIT;
        open_q <= 1'b1;
      end else if (wr_en[g] && unlocked && open_q) begin
        byte_q <= wr_data;
        if (wr_lock) open_q <= 1'b0;
      end
    end

    assign code[g] = byte_q;
  end
endmodule

// File: rtl/sc_verify_fsm.sv
`timescale 1ns/1ps
module sc_verify_fsm
  import sc_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   spend,
  input  logic                   ver_lo,
  input  logic                   ver_hi,
  input  logic [DATA_W-1:0]      ver_data,
  input  logic [1:0][DATA_W-1:0] code,
  output sc_state_e              state,
  output logic                   unlocked
);
  sc_state_e nxt;
  logic      hit_lo, hit_hi;

  always_comb begin
    hit_lo = (ver_data == code[0]);
    hit_hi = (ver_data == code[1]);
    nxt    = state;
    if (spend) begin
      nxt = ST_ARMED;
    end else if (ver_lo) begin
      if ((state == ST_ARMED || state == ST_OPEN) && hit_lo)
        nxt = (state == ST_OPEN) ? ST_OPEN : ST_HALF;
      else
        nxt = ST_IDLE;
    end else if (ver_hi) begin
      if ((state == ST_HALF || state == ST_OPEN) && hit_hi)
        nxt = ST_OPEN;
      else
        nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign unlocked = (state == ST_OPEN);
endmodule

// File: rtl/sc_read_mask.sv
`timescale 1ns/1ps
module sc_read_mask #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CNT_ADDR = '0,
  parameter logic [ADDR_W-1:0] LO_ADDR  = '0,
  parameter logic [ADDR_W-1:0] HI_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_mem_data,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == LO_ADDR || rd_addr == HI_ADDR) rd_data <= '0;
      else if (rd_addr == CNT_ADDR)                 rd_data <= cnt;
      else                                          rd_data <= rd_mem_data;
    end
  end
endmodule

// File: rtl/sc_gate.sv
`timescale 1ns/1ps
module sc_gate
  import sc_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] CNT_INIT = 8'hFF,
  parameter logic [DATA_W-1:0] CODE_LO  = 8'h3C,
  parameter logic [DATA_W-1:0] CODE_HI  = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_mem_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_grant
);
  localparam logic [ADDR_W-1:0] CNT_ADDR = {{(ADDR_W-2){1'b1}}, 2'b01};
  localparam logic [ADDR_W-1:0] LO_ADDR  = {{(ADDR_W-2){1'b1}}, 2'b10};
  localparam logic [ADDR_W-1:0] HI_ADDR  = {{(ADDR_W-2){1'b1}}, 2'b11};

  logic                   cnt_wr, spend, ver_lo, ver_hi, unlocked, code_lock;
  logic [1:0]             code_wr;
  logic [DATA_W-1:0]      cnt;
  logic [1:0][DATA_W-1:0] code;
  sc_state_e              state;

  always_comb begin
    cnt_wr     = cmd_valid && (cmd_op == OP_CNT_WR) && (cmd_addr == CNT_ADDR);
    ver_lo     = cmd_valid && (cmd_op == OP_VERIFY) && (cmd_addr == LO_ADDR);
    ver_hi     = cmd_valid && (cmd_op == OP_VERIFY) && (cmd_addr == HI_ADDR);
    code_lock  = (cmd_op == OP_CODE_WR_LOCK);
    code_wr[0] = cmd_valid && (cmd_op == OP_CODE_WR || code_lock) && (cmd_addr == LO_ADDR);
    code_wr[1] = cmd_valid && (cmd_op == OP_CODE_WR || code_lock) && (cmd_addr == HI_ADDR);
  end

  sc_attempt_ctr #(.DATA_W(DATA_W), .INIT(CNT_INIT)) u_ctr (
    .clk(clk), .rst(rst), .wr_en(cnt_wr), .wr_data(cmd_data),
    .unlocked(unlocked), .cnt(cnt), .spend(spend)
  );

  sc_code_store #(.DATA_W(DATA_W), .INIT_LO(CODE_LO), .INIT_HI(CODE_HI)) u_code (
    .clk(clk), .rst(rst), .wr_en(code_wr), .wr_lock(code_lock),
    .wr_data(cmd_data), .unlocked(unlocked), .code(code)
  );

  sc_verify_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .spend(spend), .ver_lo(ver_lo), .ver_hi(ver_hi),
    .ver_data(cmd_data), .code(code), .state(state), .unlocked(unlocked)
  );

  sc_read_mask #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CNT_ADDR(CNT_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_mem_data(rd_mem_data), .cnt(cnt), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_grant <= 1'b0;
    else     wr_grant <= unlocked;
  end
endmodule

// File: rtl/sc_gate_chk.sv
`timescale 1ns/1ps
module sc_gate_chk
  import sc_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input sc_state_e         state,
  input logic              unlocked,
  input logic [DATA_W-1:0] cnt,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_grant
);
  localparam logic [ADDR_W-1:0] LO_A = {{(ADDR_W-2){1'b1}}, 2'b10};
  localparam logic [ADDR_W-1:0] HI_A = {{(ADDR_W-2){1'b1}}, 2'b11};

  assert_clear_only_R2: assert property (@(posedge clk) disable iff (rst)
    (!unlocked) |=> ((cnt & ~$past(cnt)) == '0));

  assert_half_after_armed_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALF && $past(state) != ST_HALF) |-> ($past(state) == ST_ARMED));

  assert_open_after_half_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(state) == ST_HALF));

  assert_closed_drops_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (!unlocked) |=> !wr_grant);

  assert_exhausted_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && state == ST_IDLE) |=> (state == ST_IDLE));

  assert_code_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == LO_A || rd_addr == HI_A)) |=> (rd_data == '0));
endmodule

bind sc_gate sc_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .state(state), .unlocked(unlocked), .cnt(cnt),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_grant(wr_grant)
);

// File: tb/sim_sc_gate.sv
`timescale 1ns/1ps
module sim_sc_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [9:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       rd_en = 1'b0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_mem_data = '0;
  logic [7:0] rd_data;
  logic       wr_grant;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_gate u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_mem_data(rd_mem_data), .rd_data(rd_data),
    .wr_grant(wr_grant)
  );

  // {req[3:0], op[2:0], addr[9:0], data[7:0], exp_grant, exp_cnt[7:0]}
  localparam int NV = 21;
  localparam logic [33:0] VEC [NV] = '{
    {4'd3,  3'd1, 10'd1021, 8'hFF, 1'b0, 8'hFF},  // R3 clears nothing
    {4'd5,  3'd2, 10'd1022, 8'h3C, 1'b0, 8'hFF},  // R5 not armed
    {4'd2,  3'd1, 10'd1021, 8'hFE, 1'b0, 8'hFE},  // R2 spend bit 0
    {4'd5,  3'd2, 10'd1023, 8'hC3, 1'b0, 8'hFE},  // R5 wrong order
    {4'd2,  3'd1, 10'd1021, 8'hFC, 1'b0, 8'hFC},
    {4'd4,  3'd2, 10'd1022, 8'h3C, 1'b0, 8'hFC},
    {4'd6,  3'd2, 10'd1023, 8'h00, 1'b0, 8'hFC},  // R6 bad high byte
    {4'd2,  3'd1, 10'd1021, 8'hF8, 1'b0, 8'hF8},
    {4'd4,  3'd2, 10'd1022, 8'h3C, 1'b0, 8'hF8},
    {4'd4,  3'd2, 10'd1023, 8'hC3, 1'b1, 8'hF8},  // R4 open
    {4'd7,  3'd1, 10'd1021, 8'hFF, 1'b1, 8'hFF},  // R7 restore
    {4'd6,  3'd2, 10'd1022, 8'h11, 1'b0, 8'hFF},  // R6 mismatch when open
    {4'd2,  3'd1, 10'd1021, 8'h0F, 1'b0, 8'h0F},  // R2 AND
    {4'd11, 3'd1, 10'd1020, 8'h00, 1'b0, 8'h0F},  // R11 wrong address
    {4'd4,  3'd2, 10'd1022, 8'h3C, 1'b0, 8'h0F},
    {4'd4,  3'd2, 10'd1023, 8'hC3, 1'b1, 8'h0F},
    {4'd7,  3'd1, 10'd1021, 8'h00, 1'b1, 8'h00},  // R7 load zero
    {4'd6,  3'd2, 10'd1023, 8'h00, 1'b0, 8'h00},
    {4'd8,  3'd1, 10'd1021, 8'hFF, 1'b0, 8'h00},  // R8 cannot refill
    {4'd8,  3'd2, 10'd1022, 8'h3C, 1'b0, 8'h00},
    {4'd8,  3'd2, 10'd1023, 8'hC3, 1'b0, 8'h00}
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [9:0] a, input logic [7:0] mem, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_mem_data = mem;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][29:27], VEC[i][26:17], VEC[i][16:9]);
      chk(int'(VEC[i][33:30]), $sformatf("vec %0d grant", i), {7'd0, wr_grant}, {7'd0, VEC[i][8]});
      rd(10'd1021, 8'h00, v);
      chk(int'(VEC[i][33:30]), $sformatf("vec %0d counter", i), v, VEC[i][7:0]);
    end

    // R1 reset state and R9 read masking
    do_reset();
    chk(1, "grant after reset", {7'd0, wr_grant}, 8'h00);
    rd(10'd1021, 8'h55, v); chk(1, "counter after reset", v, 8'hFF);
    rd(10'd1022, 8'h77, v); chk(9, "low code read", v, 8'h00);
    rd(10'd1023, 8'h77, v); chk(9, "high code read", v, 8'h00);
    rd(10'd5, 8'hAB, v);    chk(9, "plain read", v, 8'hAB);

    // R10 code rewrite rules
    cmd(3'd3, 10'd1022, 8'h77);  // closed: ignored
    cmd(3'd1, 10'd1021, 8'hFE);
    cmd(3'd2, 10'd1022, 8'h3C);
    cmd(3'd2, 10'd1023, 8'hC3);
    chk(10, "factory code kept while closed", {7'd0, wr_grant}, 8'h01);
    cmd(3'd3, 10'd1022, 8'h55);
    cmd(3'd4, 10'd1022, 8'h66);
    cmd(3'd3, 10'd1022, 8'h99);  // locked: ignored
    cmd(3'd2, 10'd1022, 8'h66);
    chk(10, "new code matches", {7'd0, wr_grant}, 8'h01);
    rd(10'd1022, 8'h66, v); chk(9, "code masked while open", v, 8'h00);
    cmd(3'd2, 10'd1022, 8'h99);
    chk(10, "locked byte not rewritten", {7'd0, wr_grant}, 8'h00);

    // R8 last attempt still usable
    do_reset();
    cmd(3'd1, 10'd1021, 8'h01);
    cmd(3'd2, 10'd1022, 8'h00);
    chk(8, "wrong code fails", {7'd0, wr_grant}, 8'h00);
    cmd(3'd1, 10'd1021, 8'h00);
    cmd(3'd2, 10'd1022, 8'h3C);
    cmd(3'd2, 10'd1023, 8'hC3);
    chk(8, "final attempt opens", {7'd0, wr_grant}, 8'h01);
    cmd(3'd1, 10'd1021, 8'hFF);
    rd(10'd1021, 8'h00, v); chk(7, "restore from zero", v, 8'hFF);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule